// File: doc/BRIEF.md
# Bi-Mode Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two direction tables of two-bit saturating counters hold the outcome trends for global-history patterns. One table serves branches that currently lean taken, the other serves branches that currently lean not-taken. A third table of two-bit counters, indexed by branch address only, records each branch's current leaning and picks which direction table supplies the guess. Branches whose biases are opposite but whose history patterns are the same then land in different tables and stop overwriting each other's counters.

A front-end stage raises `pred_req` with the branch word address and reads `pred_taken` in the same cycle, because the lookup is a plain table read and a 2:1 select. When the branch resolves, the back end presents the address and the real outcome on the update port. The chosen direction counter and the choice counter are trained, and the global history register takes in the outcome. The update side does not repair speculative history. The history used by an update is the value held in the update cycle, so predicts and resolves are expected to occur in program order.

Top module: `bimode_bp`

## Requirements
- R1: After reset the history register is 0. Every choice counter and every taken-half counter holds 2'b10, and every not-taken-half counter holds 2'b01. The first prediction for any address is therefore taken and comes from the taken half.
- R2: While `pred_req` is low, `pred_taken` and `pred_use_t` are both 0. While it is high, both outputs reflect the current table contents in the same cycle, with no register between address and result.
- R3: A choice counter with MSB 1 selects the taken half (`pred_use_t` = 1). A choice counter with MSB 0 selects the not-taken half (`pred_use_t` = 0). `pred_taken` is the MSB of the selected direction counter.
- R4: The direction-table index is `addr[DIR_W-1:0]` XOR the low DIR_W bits of the history register, with the history zero-extended when it is shorter. The choice-table index is `addr[CHO_W-1:0]`.
- R5: On an update, only the direction counter in the selected half changes. It moves up by one on a taken outcome and down by one on a not-taken outcome, and it saturates at 0 and 3.
- R6: On an update, the choice counter moves one step toward the outcome and saturates at 0 and 3. It is left unchanged when its MSB disagrees with the outcome while the selected direction counter's MSB agrees with it.
- R7: Each update shifts the history register left by one and puts the outcome (1 = taken) into bit 0. With no update, the history holds its value.
- R8: When a predict and an update touch the same entries in the same cycle, the prediction reflects the contents before that update.
- R9: An update computes its indexes from the history value present in the update cycle, before that update's shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req | input | 1 | Prediction request |
| pred_addr | input | ADDR_W (10) | Branch word address for the prediction |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_use_t | output | 1 | 1 when the taken-biased half supplied the prediction |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_addr | input | ADDR_W (10) | Branch word address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| hist_q | output | HIST_W (12) | Global history register |

## Verification
A short directed sequence starts from reset. First an address is predicted with no training. Then a branch is trained not-taken so its counter in the taken half drops. A second branch is then steered onto that counter by a one-bit history change. Its next prediction shows whether the choice counter obeyed the hold exception, which separates R6 from plain toward-outcome training. A predict and an update of the same entry in one cycle, arranged so both MSBs flip, separates pre-update reads from forwarded values. A long pseudo-random stream of mixed predicts and updates over a few dozen addresses is then compared against a reference model built from the requirements. That stream shows whether the indexing and the choice of half for each update are right, because a wrong index or half causes divergence cycles later.

// File: rtl/bimode_pkg.sv
package bimode_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_MIN     = 2'b00;
    localparam ctr2_t CTR_WEAK_NT = 2'b01;
    localparam ctr2_t CTR_WEAK_T  = 2'b10;
    localparam ctr2_t CTR_MAX     = 2'b11;

    // Which direction half serves a branch
    typedef enum logic {
        HALF_NT = 1'b0,
        HALF_T  = 1'b1
    } half_e;

    // Step a two-bit counter toward the outcome, saturating at both ends
    function automatic ctr2_t ctr_train(ctr2_t c, logic up);
        ctr2_t r;
        if (up) begin
            r = (c == CTR_MAX) ? c : c + 2'd1;
        end else begin
            r = (c == CTR_MIN) ? c : c - 2'd1;
        end
        return r;
    endfunction

    function automatic logic ctr_dir(ctr2_t c);
        return c[1];
    endfunction

    // Choice counter keeps its value when it was wrong but the chosen half was right
    function automatic logic choice_hold(logic choice_dir, logic dir_dir, logic outcome);
        return (choice_dir != outcome) && (dir_dir == outcome);
    endfunction

endpackage

// File: rtl/bimode_ctr_table.sv
module bimode_ctr_table
    import bimode_pkg::*;
#(
    parameter int    IDX_W     = 10,
    parameter ctr2_t RESET_VAL = CTR_WEAK_T
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output ctr2_t            rd_a_q,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ctr2_t            rd_b_q,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr2_t            wr_d
);

    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= RESET_VAL;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_d;
        end
    end

    // Reads see the array before this cycle's write
    assign rd_a_q = mem[rd_a_idx];
    assign rd_b_q = mem[rd_b_idx];

endmodule

// File: rtl/bimode_ghr.sv
module bimode_ghr #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [HIST_W-1:0] hist_q
);

    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= shift_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= {hist_q[HIST_W-2:0], shift_in};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bimode_index.sv
module bimode_index #(
    parameter int ADDR_W = 10,
    parameter int DIR_W  = 10,
    parameter int CHO_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DIR_W-1:0]  hist_fold,
    output logic [DIR_W-1:0]  dir_idx,
    output logic [CHO_W-1:0]  cho_idx
);

    assign dir_idx = addr[DIR_W-1:0] ^ hist_fold;
    assign cho_idx = addr[CHO_W-1:0];

endmodule

// File: rtl/bimode_bp.sv
module bimode_bp
    import bimode_pkg::*;
#(
    parameter  int DIR_W  = 10,
    parameter  int CHO_W  = 9,
    parameter  int HIST_W = 12,
    localparam int ADDR_W = (DIR_W > CHO_W) ? DIR_W : CHO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pred_req,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    output logic              pred_use_t,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    output logic [HIST_W-1:0] hist_q
);

    logic [HIST_W-1:0] ghr;
    logic [DIR_W-1:0]  hist_fold;

    // History folded onto the direction index width
    generate
        if (HIST_W >= DIR_W) begin : g_hist_trunc
            assign hist_fold = ghr[DIR_W-1:0];
        end else begin : g_hist_ext
            assign hist_fold = {{(DIR_W-HIST_W){1'b0}}, ghr};
        end
    endgenerate

    logic [DIR_W-1:0] pred_dir_idx, upd_dir_idx;
    logic [CHO_W-1:0] pred_cho_idx, upd_cho_idx;

    bimode_index #(.ADDR_W(ADDR_W), .DIR_W(DIR_W), .CHO_W(CHO_W)) u_pred_idx (
        .addr      (pred_addr),
        .hist_fold (hist_fold),
        .dir_idx   (pred_dir_idx),
        .cho_idx   (pred_cho_idx)
    );

    bimode_index #(.ADDR_W(ADDR_W), .DIR_W(DIR_W), .CHO_W(CHO_W)) u_upd_idx (
        .addr      (upd_addr),
        .hist_fold (hist_fold),
        .dir_idx   (upd_dir_idx),
        .cho_idx   (upd_cho_idx)
    );

    // Choice table
    ctr2_t cho_pred_q, cho_old, cho_new;

    bimode_ctr_table #(.IDX_W(CHO_W), .RESET_VAL(CTR_WEAK_T)) u_cho_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (pred_cho_idx),
        .rd_a_q   (cho_pred_q),
        .rd_b_idx (upd_cho_idx),
        .rd_b_q   (cho_old),
        .wr_en    (upd_valid),
        .wr_idx   (upd_cho_idx),
        .wr_d     (cho_new)
    );

    // Direction tables: index 0 = not-taken half, 1 = taken half
    ctr2_t dir_pred_q [2];
    ctr2_t dir_upd_q  [2];
    logic  dir_wr_en  [2];
    ctr2_t upd_dir_old, upd_dir_new;
    half_e pred_half, upd_half;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_dir
            assign dir_wr_en[g] = upd_valid && (upd_half == half_e'(g));

            bimode_ctr_table #(
                .IDX_W     (DIR_W),
                .RESET_VAL ((g == 1) ? CTR_WEAK_T : CTR_WEAK_NT)
            ) u_dir_tbl (
                .clk      (clk),
                .rst      (rst),
                .rd_a_idx (pred_dir_idx),
                .rd_a_q   (dir_pred_q[g]),
                .rd_b_idx (upd_dir_idx),
                .rd_b_q   (dir_upd_q[g]),
                .wr_en    (dir_wr_en[g]),
                .wr_idx   (upd_dir_idx),
                .wr_d     (upd_dir_new)
            );
        end
    endgenerate

    // Prediction path
    ctr2_t pred_ctr;

    always_comb begin
        pred_half  = half_e'(ctr_dir(cho_pred_q));
        pred_ctr   = dir_pred_q[pred_half];
        pred_taken = pred_req && ctr_dir(pred_ctr);
        pred_use_t = pred_req && (pred_half == HALF_T);
    end

    // Update path
    always_comb begin
        upd_half    = half_e'(ctr_dir(cho_old));
        upd_dir_old = dir_upd_q[upd_half];
        upd_dir_new = ctr_train(upd_dir_old, upd_taken);
        if (choice_hold(ctr_dir(cho_old), ctr_dir(upd_dir_old), upd_taken)) begin
            cho_new = cho_old;
        end else begin
            cho_new = ctr_train(cho_old, upd_taken);
        end
    end

    bimode_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .shift_in (upd_taken),
        .hist_q   (ghr)
    );

    assign hist_q = ghr;

endmodule

// File: rtl/bimode_bp_chk.sv
module bimode_bp_chk
    import bimode_pkg::*;
#(
    parameter int HIST_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              pred_req,
    input logic              pred_taken,
    input logic              pred_use_t,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] hist_q,
    input ctr2_t             upd_dir_old,
    input ctr2_t             upd_dir_new,
    input ctr2_t             cho_old,
    input ctr2_t             cho_new
);

    // R2: no request, quiet outputs
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !pred_req |-> (!pred_taken && !pred_use_t));

    // R7: shift on update
    a_r7_hist_shift: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> hist_q == (($past(hist_q) << 1) | HIST_W'($past(upd_taken))));

    // R7: hold without update
    a_r7_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(hist_q));

    // R5: taken outcome steps the chosen counter up by one or holds at 3
    a_r5_dir_up: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |->
            ((upd_dir_old == 2'b11) ? (upd_dir_new == 2'b11)
                                    : (upd_dir_new == upd_dir_old + 2'd1)));

    // R5: not-taken outcome steps down by one or holds at 0
    a_r5_dir_down: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken) |->
            ((upd_dir_old == 2'b00) ? (upd_dir_new == 2'b00)
                                    : (upd_dir_new == upd_dir_old - 2'd1)));

    // R6: exception case leaves the choice counter alone
    a_r6_cho_hold: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && (cho_old[1] != upd_taken) && (upd_dir_old[1] == upd_taken))
            |-> (cho_new == cho_old));

    // R6: otherwise the choice counter moves at most one step
    a_r6_cho_step: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> ($countones(cho_new ^ cho_old) <= 2) &&
                      ((cho_new == cho_old) || (cho_new == cho_old + 2'd1) ||
                       (cho_new == cho_old - 2'd1)));

endmodule

bind bimode_bp bimode_bp_chk #(.HIST_W(HIST_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pred_req    (pred_req),
    .pred_taken  (pred_taken),
    .pred_use_t  (pred_use_t),
    .upd_valid   (upd_valid),
    .upd_taken   (upd_taken),
    .hist_q      (hist_q),
    .upd_dir_old (upd_dir_old),
    .upd_dir_new (upd_dir_new),
    .cho_old     (cho_old),
    .cho_new     (cho_new)
);

// File: tb/bimode_bp_tb.sv
`timescale 1ns/1ps
module bimode_bp_tb;

    localparam int DIR_W  = 10;
    localparam int CHO_W  = 9;
    localparam int HIST_W = 12;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pred_req = 1'b0;
    logic [ADDR_W-1:0] pred_addr = '0;
    logic              pred_taken;
    logic              pred_use_t;
    logic              upd_valid = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic              upd_taken = 1'b0;
    logic [HIST_W-1:0] hist_q;

    always #2 clk = ~clk;

    bimode_bp #(.DIR_W(DIR_W), .CHO_W(CHO_W), .HIST_W(HIST_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pred_req   (pred_req),
        .pred_addr  (pred_addr),
        .pred_taken (pred_taken),
        .pred_use_t (pred_use_t),
        .upd_valid  (upd_valid),
        .upd_addr   (upd_addr),
        .upd_taken  (upd_taken),
        .hist_q     (hist_q)
    );

    typedef struct {
        logic  taken;
        logic  use_t;
        int    hist;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Reference state built from the requirements
    int m_dt [1 << DIR_W];
    int m_dn [1 << DIR_W];
    int m_ch [1 << CHO_W];
    int m_hist;

    task automatic model_reset();
        for (int i = 0; i < (1 << DIR_W); i++) begin
            m_dt[i] = 2;
            m_dn[i] = 1;
        end
        for (int i = 0; i < (1 << CHO_W); i++) m_ch[i] = 2;
        m_hist = 0;
    endtask

    function automatic int sat(int c, bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic check(string tag, int got, int exp_v);
        n_checks++;
        if (got != exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp_v);
        end
    endtask

    // Driver: apply one cycle of stimulus, push expectation, advance the model
    task automatic step(bit req, int paddr, bit upd, int uaddr, bit ut, string tag);
        exp_t e;
        int   ci, di, s, d;
        @(posedge clk);
        #1;
        pred_req  = req;
        pred_addr = ADDR_W'(paddr);
        upd_valid = upd;
        upd_addr  = ADDR_W'(uaddr);
        upd_taken = ut;
        e.tag  = tag;
        e.hist = m_hist;
        e.taken = 1'b0;
        e.use_t = 1'b0;
        if (req) begin
            ci = paddr & ((1 << CHO_W) - 1);
            di = (paddr ^ m_hist) & ((1 << DIR_W) - 1);
            e.use_t = (m_ch[ci] >= 2);
            e.taken = e.use_t ? (m_dt[di] >= 2) : (m_dn[di] >= 2);
        end
        q.push_back(e);
        if (upd) begin
            ci = uaddr & ((1 << CHO_W) - 1);
            di = (uaddr ^ m_hist) & ((1 << DIR_W) - 1);
            s  = (m_ch[ci] >= 2);
            d  = s ? m_dt[di] : m_dn[di];
            if (s) m_dt[di] = sat(d, ut); else m_dn[di] = sat(d, ut);
            if (!((s != ut) && ((d >= 2) == ut))) m_ch[ci] = sat(m_ch[ci], ut);
            m_hist = ((m_hist << 1) | ut) & ((1 << HIST_W) - 1);
        end
    endtask

    // Monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " pred_taken"}, pred_taken, e.taken);
            check({e.tag, " pred_use_t"}, pred_use_t, e.use_t);
            check("R7 hist_q", hist_q, e.hist);
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned lfsr;
        int a, b;
        model_reset();
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1: fresh state predicts taken from the taken half, history zero
        step(1, 'h055, 0, 0, 0, "R1");
        // R2: no request gives quiet outputs
        step(0, 'h055, 0, 0, 0, "R2");

        // R6 exception: lower taken-half counter at 0x040, then steer 0x041 onto it
        step(0, 0, 1, 'h040, 0, "R5");
        step(0, 0, 1, 'h100, 1, "R9");
        step(0, 0, 1, 'h041, 0, "R6");
        step(1, 'h041, 0, 0, 0, "R6");

        // R8: same-cycle predict and update of one entry, both MSBs would flip
        step(1, 'h040, 1, 'h040, 1, "R8");
        step(1, 'h040, 0, 0, 0, "R8");

        // R5: saturation while training one branch repeatedly
        for (int i = 0; i < 8; i++) step(1, 'h0AA, 1, 'h0AA, 1, "R5");
        for (int i = 0; i < 6; i++) step(1, 'h0AA, 1, 'h0AA, 0, "R5");
        for (int i = 0; i < 14; i++) step(1, 'h133, 1, 'h133, 0, "R3");
        step(1, 'h133, 0, 0, 0, "R3");

        // R4: pseudo-random mix over a small address pool
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 1500; i++) begin
            lfsr ^= lfsr << 13;
            lfsr ^= lfsr >> 17;
            lfsr ^= lfsr << 5;
            a = (lfsr & 32'h1F) * 37 + ((lfsr >> 5) & 32'h3);
            b = ((lfsr >> 8) & 32'h1F) * 37 + ((lfsr >> 13) & 32'h3);
            step(lfsr[20], a, lfsr[21] | lfsr[22], b, lfsr[23] ^ (b[0] & lfsr[24]),
                 (i < 750) ? "R4" : "R9");
        end

        step(0, 0, 0, 0, 0, "R2");
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule